// File: doc/BRIEF.md
# Phased Logic Dual-Rail Gate

This block is a clock-sampled model of one gate primitive from a phased-logic network. Each input and the output is a dual-rail pair made of a value rail and a timing rail. The phase of a pair is the XOR of its two rails. A new token is sent by setting the value rail to the data value and choosing the timing rail so that the phase flips. Because of this, exactly one rail moves for each token, and no return-to-zero step is needed between tokens.

The gate has an internal phase bit. On every sampling edge it compares the phase of each input with its own phase. When all of them agree, the gate fires. A firing evaluates the combinational function of the input values, drives a new output token, flips the internal phase and raises a one-cycle `fire` strobe. When the phases do not all agree, nothing changes.

A normal gate drives an output token whose phase is the opposite of its phase before the firing. A phase-inverted gate, selected by a parameter, drives an output token whose phase equals its phase before the firing. Placing one inverted gate in each loop gives a network an initial token marking that is both live (every loop can keep firing) and safe (no edge ever holds two tokens at once).

The controller has two states that encode the gate phase: `ST_EVEN` (phase 0) and `ST_ODD` (phase 1). It has three transitions:
- `fire_even`: from `ST_EVEN` to `ST_ODD`, taken when every input phase is 0.
- `fire_odd`: from `ST_ODD` to `ST_EVEN`, taken when every input phase is 1.
- `hold`: stays in the current state in every other case.

Top module: `phl_gate`

## Requirements
- R1: While `rst` is high, and after it is released until the first firing, `gate_phase` is 0, `fire` is 0 and `out_v` is 0. `out_t` is 0 on a normal gate and 1 on an inverted gate (INVERT=1).
- R2: The gate fires on a sampling edge if and only if, at that edge, `in_v[i]^in_t[i]` equals `gate_phase` for every input i. The firing makes `fire` 1 for exactly the following cycle. A partial match never fires.
- R3: Each firing flips `gate_phase`. Without a firing, `gate_phase` holds its value.
- R4: After a firing, `out_v` equals the gate function of the `in_v` values sampled at the firing edge. FUNC selects the function: PL_AND (2'd0, the default), PL_OR (2'd1), PL_XOR (2'd2), or PL_BUF (2'd3), which passes `in_v[0]` through.
- R5: On a normal gate (INVERT=0), the output phase `out_v^out_t` after a firing is the inverse of `gate_phase` before that firing.
- R6: On an inverted gate (INVERT=1), the output phase after a firing equals `gate_phase` before that firing.
- R7: Each firing changes exactly one of `out_v` and `out_t`. Without a firing, neither rail changes.
- R8: After a firing, if the inputs do not all flip their phase, the gate does not fire again, and its outputs and `gate_phase` stay unchanged.
- R9: In a ring of single-input pass-through gates that contains exactly one inverted gate, tokens keep circulating. Every gate fires repeatedly, and the firing counts of the gates stay within 2 of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| in_v | input | N_IN | Value rails of the inputs |
| in_t | input | N_IN | Timing rails of the inputs |
| out_v | output | 1 | Value rail of the output |
| out_t | output | 1 | Timing rail of the output |
| fire | output | 1 | One-cycle strobe for each firing |
| gate_phase | output | 1 | Current phase of the gate |

## Verification
The bound checker verifies the per-cycle rules on every cycle:
- a firing follows full phase agreement, and full agreement always leads to a firing;
- the gate phase flips only on a firing;
- exactly one output rail moves per firing, and no rail moves otherwise;
- the output phase has the value that INVERT selects.

Some behaviours can only be shown by the bench scenarios, which compare against a token model:
- the computed function values for AND and XOR;
- refusal under partial phase toggles;
- idling after a firing while the inputs are held;
- steady circulation of tokens around a three-gate ring that contains one inverted gate.

// File: rtl/phl_pkg.sv
package phl_pkg;

    // Combinational function evaluated by a gate when it fires
    typedef enum logic [1:0] {
        PL_AND = 2'd0,
        PL_OR  = 2'd1,
        PL_XOR = 2'd2,
        PL_BUF = 2'd3
    } phl_func_e;

    // Controller state; the state itself is the gate phase
    typedef enum logic {
        ST_EVEN = 1'b0,
        ST_ODD  = 1'b1
    } phl_state_e;

endpackage

// File: rtl/phl_phase_detect.sv
module phl_phase_detect #(
    parameter int N_IN = 2
) (
    input  logic [N_IN-1:0] in_v,
    input  logic [N_IN-1:0] in_t,
    input  logic            gate_phase,
    output logic            enable
);
    logic [N_IN-1:0] agree;

    // Per-input comparison of the pair phase against the gate phase
    for (genvar i = 0; i < N_IN; i++) begin : g_in
        logic pair_phase;
        assign pair_phase = in_v[i] ^ in_t[i];
        assign agree[i]   = (pair_phase == gate_phase);
    end

    assign enable = &agree;
endmodule

// File: rtl/phl_func_eval.sv
module phl_func_eval
    import phl_pkg::*;
#(
    parameter int        N_IN = 2,
    parameter phl_func_e FUNC = PL_AND
) (
    input  logic [N_IN-1:0] in_v,
    output logic            result
);
    if (FUNC == PL_AND) begin : g_and
        assign result = &in_v;
    end else if (FUNC == PL_OR) begin : g_or
        assign result = |in_v;
    end else if (FUNC == PL_XOR) begin : g_xor
        assign result = ^in_v;
    end else begin : g_buf
        logic [N_IN-1:0] pass_sel;
        assign pass_sel = in_v & {{(N_IN-1){1'b0}}, 1'b1};
        assign result   = |pass_sel;
    end
endmodule

// File: rtl/phl_ledr_encode.sv
module phl_ledr_encode (
    input  logic value,
    input  logic target_phase,
    output logic rail_v,
    output logic rail_t
);
    // Value rail carries data; timing rail makes the pair phase the target
    assign rail_v = value;
    assign rail_t = value ^ target_phase;
endmodule

// File: rtl/phl_gate.sv
module phl_gate
    import phl_pkg::*;
#(
    parameter int        N_IN   = 2,
    parameter phl_func_e FUNC   = PL_AND,
    parameter bit        INVERT = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] in_v,
    input  logic [N_IN-1:0] in_t,
    output logic            out_v,
    output logic            out_t,
    output logic            fire,
    output logic            gate_phase
);
    localparam logic RST_OUT_T = INVERT;

    phl_state_e state_q;
    phl_state_e state_d;
    logic       enable;
    logic       func_val;
    logic       tgt_phase;
    logic       nxt_v;
    logic       nxt_t;

    assign gate_phase = (state_q == ST_ODD);

    phl_phase_detect #(.N_IN(N_IN)) u_detect (
        .in_v       (in_v),
        .in_t       (in_t),
        .gate_phase (gate_phase),
        .enable     (enable)
    );

    phl_func_eval #(.N_IN(N_IN), .FUNC(FUNC)) u_func (
        .in_v   (in_v),
        .result (func_val)
    );

    // Output phase rule: normal gates invert, phase-inverted gates follow
    if (INVERT) begin : g_inv
        assign tgt_phase = gate_phase;
    end else begin : g_norm
        assign tgt_phase = ~gate_phase;
    end

    phl_ledr_encode u_enc (
        .value        (func_val),
        .target_phase (tgt_phase),
        .rail_v       (nxt_v),
        .rail_t       (nxt_t)
    );

    // Next-state logic: fire_even, fire_odd, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EVEN: if (enable) state_d = ST_ODD;
            ST_ODD:  if (enable) state_d = ST_EVEN;
            default: state_d = ST_EVEN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EVEN;
        else     state_q <= state_d;
    end

    // Output register: new token and firing strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            out_v <= 1'b0;
            out_t <= RST_OUT_T;
            fire  <= 1'b0;
        end else begin
            fire <= enable;
            if (enable) begin
                out_v <= nxt_v;
                out_t <= nxt_t;
            end
        end
    end
endmodule

// File: rtl/phl_gate_chk.sv
module phl_gate_chk #(
    parameter int N_IN   = 2,
    parameter bit INVERT = 1'b0
) (
    input logic            clk,
    input logic            rst,
    input logic [N_IN-1:0] in_v,
    input logic [N_IN-1:0] in_t,
    input logic            out_v,
    input logic            out_t,
    input logic            fire,
    input logic            gate_phase
);
    logic in_match;
    assign in_match = ((in_v ^ in_t) == {N_IN{gate_phase}});

    AST_FIRE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        fire |-> $past(in_match)); // R2
    AST_MATCH_FIRES: assert property (@(posedge clk) disable iff (rst)
        in_match |=> fire); // R2
    AST_PHASE_FLIPS: assert property (@(posedge clk) disable iff (rst)
        fire |-> (gate_phase != $past(gate_phase))); // R3
    AST_PHASE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !fire |-> $stable(gate_phase)); // R3
    AST_ONE_RAIL: assert property (@(posedge clk) disable iff (rst)
        fire |-> ($countones({out_v, out_t} ^ $past({out_v, out_t})) == 1)); // R7
    AST_RAILS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !fire |-> ($stable(out_v) && $stable(out_t))); // R7
    AST_OUT_PHASE_NORM: assert property (@(posedge clk) disable iff (rst)
        (fire && !INVERT) |-> ((out_v ^ out_t) == !$past(gate_phase))); // R5
    AST_OUT_PHASE_INV: assert property (@(posedge clk) disable iff (rst)
        (fire && INVERT) |-> ((out_v ^ out_t) == $past(gate_phase))); // R6
endmodule

bind phl_gate phl_gate_chk #(.N_IN(N_IN), .INVERT(INVERT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_v       (in_v),
    .in_t       (in_t),
    .out_v      (out_v),
    .out_t      (out_t),
    .fire       (fire),
    .gate_phase (gate_phase)
);

// File: tb/phl_gate_tb_top.sv
`timescale 1ns/1ps
module phl_gate_tb_top;
    import phl_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Instance A: default 2-input AND, normal phase
    logic [1:0] a_v = '0, a_t = '0;
    logic a_ov, a_ot, a_fire, a_ph;
    phl_gate dut_i (
        .clk(clk), .rst(rst), .in_v(a_v), .in_t(a_t),
        .out_v(a_ov), .out_t(a_ot), .fire(a_fire), .gate_phase(a_ph)
    );

    // Instance X: 3-input XOR, phase inverted
    logic [2:0] x_v = '0, x_t = '0;
    logic x_ov, x_ot, x_fire, x_ph;
    phl_gate #(.N_IN(3), .FUNC(PL_XOR), .INVERT(1'b1)) dut_x (
        .clk(clk), .rst(rst), .in_v(x_v), .in_t(x_t),
        .out_v(x_ov), .out_t(x_ot), .fire(x_fire), .gate_phase(x_ph)
    );

    // Ring of three pass-through gates, gate 0 phase inverted
    logic [2:0] r_v, r_t, r_fire, r_ph;
    for (genvar g = 0; g < 3; g++) begin : g_ring
        phl_gate #(.N_IN(1), .FUNC(PL_BUF), .INVERT(g == 0)) u_g (
            .clk(clk), .rst(rst),
            .in_v(r_v[(g+2)%3]), .in_t(r_t[(g+2)%3]),
            .out_v(r_v[g]), .out_t(r_t[g]), .fire(r_fire[g]), .gate_phase(r_ph[g])
        );
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Scoreboard queues hold {out_v, out_t, gate_phase} expected after each firing
    logic [2:0] qa[$];
    logic [2:0] qx[$];
    logic ma_ph = 1'b0;
    logic mx_ph = 1'b0;

    task automatic upd_a(input logic [1:0] val, input logic [1:0] mask);
        logic np, f, p;
        for (int i = 0; i < 2; i++) begin
            if (mask[i]) begin
                np = ~(a_v[i] ^ a_t[i]);
                a_v[i] = val[i];
                a_t[i] = val[i] ^ np;
            end
        end
        if ((a_v ^ a_t) == {2{ma_ph}}) begin
            f = &a_v;
            p = ~ma_ph;          // normal gate: opposite phase (R5)
            qa.push_back({f, f ^ p, ~ma_ph});
            ma_ph = ~ma_ph;
        end
    endtask

    task automatic upd_x(input logic [2:0] val, input logic [2:0] mask);
        logic np, f, p;
        for (int i = 0; i < 3; i++) begin
            if (mask[i]) begin
                np = ~(x_v[i] ^ x_t[i]);
                x_v[i] = val[i];
                x_t[i] = val[i] ^ np;
            end
        end
        if ((x_v ^ x_t) == {3{mx_ph}}) begin
            f = ^x_v;
            p = mx_ph;           // inverted gate: same phase (R6)
            qx.push_back({f, f ^ p, ~mx_ph});
            mx_ph = ~mx_ph;
        end
    endtask

    // Monitors: pop and compare on each firing, rail-change rule every cycle
    logic [1:0] a_prev, x_prev;
    always @(negedge clk) begin
        if (!rst) begin
            if (a_fire) begin
                if (qa.size() == 0) check(1'b0, "R2 A unexpected fire", 1, 0);
                else begin
                    logic [2:0] e;
                    e = qa.pop_front();
                    check({a_ov, a_ot, a_ph} == e, "R4/R5/R3 A token", {a_ov, a_ot, a_ph}, e);
                end
                check($countones({a_ov, a_ot} ^ a_prev) == 1, "R7 A one rail", {a_ov, a_ot}, a_prev);
            end else begin
                check({a_ov, a_ot} == a_prev, "R7 A rails quiet", {a_ov, a_ot}, a_prev);
            end
            if (x_fire) begin
                if (qx.size() == 0) check(1'b0, "R2 X unexpected fire", 1, 0);
                else begin
                    logic [2:0] e;
                    e = qx.pop_front();
                    check({x_ov, x_ot, x_ph} == e, "R4/R6/R3 X token", {x_ov, x_ot, x_ph}, e);
                end
                check($countones({x_ov, x_ot} ^ x_prev) == 1, "R7 X one rail", {x_ov, x_ot}, x_prev);
            end
        end
        a_prev = {a_ov, a_ot};
        x_prev = {x_ov, x_ot};
    end

    int r_cnt[3] = '{0, 0, 0};
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 3; i++) if (r_fire[i]) r_cnt[i]++;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        int mx, mn;
        logic sv_ph;
        logic [1:0] sv_out;
        repeat (3) tick();
        // R1: reset state
        check({a_ov, a_ot, a_fire, a_ph} == 4'b0000, "R1 A reset", {a_ov, a_ot, a_fire, a_ph}, 0);
        check({x_ov, x_ot, x_fire, x_ph} == 4'b0100, "R1 X reset", {x_ov, x_ot, x_fire, x_ph}, 4);
        // Release reset; inputs already agree with phase 0, so both gates fire first
        tick();
        rst = 1'b0;
        upd_a(2'b00, 2'b00);
        upd_x(3'b000, 3'b000);
        // R4/R2: full toggles with every AND input pattern
        for (int k = 0; k < 8; k++) begin
            tick();
            upd_a(2'(k), 2'b11);
        end
        // R2: partial toggles must not fire until the last input arrives
        tick(); upd_a(2'b11, 2'b01);
        tick(); upd_a(2'b11, 2'b00);
        tick(); upd_a(2'b11, 2'b10);
        tick(); upd_a(2'b10, 2'b10);
        tick(); upd_a(2'b00, 2'b01);
        // R8: hold inputs after a firing; nothing may change
        repeat (2) tick();
        sv_ph  = a_ph;
        sv_out = {a_ov, a_ot};
        repeat (5) tick();
        check(a_ph == sv_ph, "R8 A phase held", a_ph, sv_ph);
        check({a_ov, a_ot} == sv_out, "R8 A output held", {a_ov, a_ot}, sv_out);
        check(a_fire == 1'b0, "R8 A no fire while held", a_fire, 0);
        // R4/R6: inverted XOR gate with every input pattern
        for (int k = 0; k < 16; k++) begin
            tick();
            upd_x(3'(k * 5 + 1), 3'b111);
        end
        tick(); upd_x(3'b101, 3'b001);
        tick(); upd_x(3'b101, 3'b110);
        tick(); upd_x(3'b010, 3'b011);
        tick(); upd_x(3'b110, 3'b100);
        repeat (60) tick();
        check(qa.size() == 0, "R2 A all expected firings seen", qa.size(), 0);
        check(qx.size() == 0, "R2 X all expected firings seen", qx.size(), 0);
        // R9: ring keeps circulating
        mx = r_cnt[0]; mn = r_cnt[0];
        for (int i = 1; i < 3; i++) begin
            if (r_cnt[i] > mx) mx = r_cnt[i];
            if (r_cnt[i] < mn) mn = r_cnt[i];
        end
        check(mn >= 20, "R9 ring every gate fires", mn, 20);
        check(mx - mn <= 2, "R9 ring counts balanced", mx - mn, 2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule